// File: doc/BRIEF.md
# Scored Branch Target Address Cache

This block is a small fully associative table that sits beside instruction fetch and guesses where fetch should go next. Every fetch address offered to it is compared against all stored tags in the cycle it arrives; one cycle later the block reports whether a matching entry exists, whether that entry is trusted enough to redirect fetch, and the redirect address. Each entry keeps a short tag, the low-order bits of a target address and a saturating confidence score. Entries whose score is low still match but do not redirect, so branches that keep changing their target cost nothing beyond the normal fetch path.

When a fetch resolves, the pipeline reports the outcome through a resolve port: the tag key of the resolved fetch address, whether a taken exit happened, the low bits of its actual target, and whether the earlier prediction was right. A matching entry has its score moved up or down. A taken exit that found no entry gets a new entry with score zero; the slot is picked by validity first and by score after that. Addresses are instruction word addresses, so every bit of the address is meaningful.

Both input ports are valid-only streams. The block accepts a beat on every cycle its valid is high and never applies back-pressure, so there is no ready signal; a lookup and a resolve may arrive in the same cycle. The prediction outputs are a valid-qualified stream with no ready either: the consumer must take each beat in the cycle it appears.

Top module: `sc_btac`

## Requirements
- R1: After reset every entry is invalid, so a lookup made right after reset reports no hit and no redirect.
- R2: The prediction outputs are registered: `pred_valid` is high in exactly the cycle after a cycle with `fetch_valid` high, and `pred_hit`/`pred_redirect` are low whenever `pred_valid` is low.
- R3: A lookup hits when a valid entry's tag equals `fetch_addr[TAG_W-1:0]` (default bits 15:0); fetch addresses that agree in those bits match the same entry, and at most one entry ever matches.
- R4: `pred_redirect` is high only when the lookup hit and the matching entry's score is at least 2; a hit on an entry with score 0 or 1 gives `pred_hit` high and `pred_redirect` low.
- R5: `pred_target` equals `fetch_addr[63:16]` of the looked-up address joined with the 16 stored target bits of the matching entry.
- R6: A resolve that matches an entry adds one to its 2-bit score when `res_correct` is high, saturating at 3, and subtracts one when it is low, saturating at 0.
- R7: A resolve that matches no entry and has `res_taken` high writes a valid entry with the resolved tag, the resolved target bits and score 0; one with `res_taken` low changes nothing.
- R8: An allocation uses the lowest-indexed invalid entry if any exists; otherwise it replaces the entry with the lowest score, ties going to the lowest index.
- R9: A lookup and a resolve in the same cycle give a lookup result computed from the table contents before that resolve takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch address is offered this cycle |
| fetch_addr | input | 64 | Fetch word address to look up |
| pred_valid | output | 1 | Lookup result present (one cycle after the fetch) |
| pred_hit | output | 1 | A valid entry matched the looked-up tag |
| pred_redirect | output | 1 | Fetch should go to `pred_target` |
| pred_target | output | 64 | Predicted next fetch address |
| res_valid | input | 1 | A resolved outcome is reported this cycle |
| res_key | input | 16 | Tag bits of the resolved fetch address |
| res_taken | input | 1 | A taken exit occurred for that fetch |
| res_target_lo | input | 16 | Low-order bits of the actual target |
| res_correct | input | 1 | The earlier prediction for that fetch was right |

## Verification
The score is walked through climbs, drops and both saturation points with a lookup after each step, so a counter that wraps instead of saturating, or a threshold that is off by one, shows up as a wrong redirect. Lookups with addresses that differ only above the tag, and only inside it, separate correct tag slicing from aliasing errors and confirm that the upper target bits come from the current fetch. Filling all eight slots and then allocating twice with mixed scores tells invalid-first placement from score-based placement and checks the lowest-index tie rule. Lookups issued in the same cycle as a score change or an allocation confirm that they see the old contents.

// File: rtl/sc_btac_pkg.sv
package sc_btac_pkg;
  localparam int SCORE_W = 2;
  typedef logic [SCORE_W-1:0] score_t;
  localparam score_t SCORE_MAX = '1;

  function automatic score_t score_up(score_t s);
    return (s == SCORE_MAX) ? s : s + score_t'(1);
  endfunction

  function automatic score_t score_down(score_t s);
    return (s == '0) ? s : s - score_t'(1);
  endfunction
endpackage

// File: rtl/sc_btac_match.sv
module sc_btac_match #(
  parameter int N_ENT = 8,
  parameter int TAG_W = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] ent_v,
  input  logic [TAG_W-1:0] ent_tag [N_ENT],
  input  logic [TAG_W-1:0] key,
  output logic [N_ENT-1:0] hit_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = ent_v[g] && (ent_tag[g] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sc_btac_victim.sv
module sc_btac_victim
  import sc_btac_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] ent_v,
  input  score_t           ent_sc [N_ENT],
  output logic [IDX_W-1:0] vic_idx
);
  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] low_idx;
  score_t           low_sc;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!ent_v[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    low_sc  = ent_sc[0];
    low_idx = '0;
    for (int i = 1; i < N_ENT; i++) begin
      if (ent_sc[i] < low_sc) begin
        low_sc  = ent_sc[i];
        low_idx = IDX_W'(i);
      end
    end
  end

  assign vic_idx = have_free ? free_idx : low_idx;

  AST_FREE_SLOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ent_v) |-> !ent_v[vic_idx]); // R8
endmodule

// File: rtl/sc_btac.sv
module sc_btac
  import sc_btac_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int N_ENT  = 8,
  parameter int TAG_W  = 16,
  parameter int TGT_W  = 16,
  parameter int THRESH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_redirect,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_key,
  input  logic              res_taken,
  input  logic [TGT_W-1:0]  res_target_lo,
  input  logic              res_correct
);
  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0] ent_v;
  logic [TAG_W-1:0] ent_tag [N_ENT];
  logic [TGT_W-1:0] ent_tgt [N_ENT];
  score_t           ent_sc  [N_ENT];

  // lookup side
  logic [N_ENT-1:0] lk_vec;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic             lk_strong;

  sc_btac_match #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_lk_match (
    .ent_v   (ent_v),
    .ent_tag (ent_tag),
    .key     (fetch_addr[TAG_W-1:0]),
    .hit_vec (lk_vec),
    .hit     (lk_hit),
    .hit_idx (lk_idx)
  );

  assign lk_strong = int'(ent_sc[lk_idx]) >= THRESH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid    <= 1'b0;
      pred_hit      <= 1'b0;
      pred_redirect <= 1'b0;
      pred_target   <= '0;
    end else begin
      pred_valid    <= fetch_valid;
      pred_hit      <= fetch_valid && lk_hit;
      pred_redirect <= fetch_valid && lk_hit && lk_strong;
      pred_target   <= {fetch_addr[ADDR_W-1:TGT_W], ent_tgt[lk_idx]};
    end
  end

  // resolve side
  logic [N_ENT-1:0] rs_vec;
  logic             rs_hit;
  logic [IDX_W-1:0] rs_idx;
  logic [IDX_W-1:0] vic_idx;
  logic             do_alloc;

  sc_btac_match #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_rs_match (
    .ent_v   (ent_v),
    .ent_tag (ent_tag),
    .key     (res_key),
    .hit_vec (rs_vec),
    .hit     (rs_hit),
    .hit_idx (rs_idx)
  );

  sc_btac_victim #(.N_ENT(N_ENT)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .ent_v   (ent_v),
    .ent_sc  (ent_sc),
    .vic_idx (vic_idx)
  );

  assign do_alloc = res_valid && !rs_hit && res_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        ent_tag[i] <= '0;
        ent_tgt[i] <= '0;
        ent_sc[i]  <= '0;
      end
    end else if (res_valid && rs_hit) begin
      ent_sc[rs_idx] <= res_correct ? score_up(ent_sc[rs_idx]) : score_down(ent_sc[rs_idx]);
    end else if (do_alloc) begin
      ent_v[vic_idx]   <= 1'b1;
      ent_tag[vic_idx] <= res_key;
      ent_tgt[vic_idx] <= res_target_lo;
      ent_sc[vic_idx]  <= '0;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec)); // R3
  AST_RESULT_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> pred_valid); // R2
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !pred_valid && !pred_hit); // R2
  AST_REDIRECT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_redirect |-> pred_hit); // R4
  AST_UPPER_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> pred_target[ADDR_W-1:TGT_W] == $past(fetch_addr[ADDR_W-1:TGT_W])); // R5
  AST_NEW_ENTRY_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |=> ent_v[$past(vic_idx)] && ent_sc[$past(vic_idx)] == '0); // R7
endmodule

// File: tb/test_sc_btac.sv
module test_sc_btac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_addr = '0;
  logic        pred_valid, pred_hit, pred_redirect;
  logic [63:0] pred_target;
  logic        res_valid = 1'b0;
  logic [15:0] res_key = '0;
  logic        res_taken = 1'b0;
  logic [15:0] res_target_lo = '0;
  logic        res_correct = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sc_btac i_sc_btac (
    .clk, .rst_n, .fetch_valid, .fetch_addr,
    .pred_valid, .pred_hit, .pred_redirect, .pred_target,
    .res_valid, .res_key, .res_taken, .res_target_lo, .res_correct
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_valid = 1'b0; res_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Look up and check: result sampled one negedge later (one register stage).
  task automatic lookup(string req, logic [63:0] a, logic e_hit, logic e_red, logic [15:0] e_tlo);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    check({req, " valid"}, 64'(pred_valid), 64'(1'b1));
    check({req, " hit"}, 64'(pred_hit), 64'(e_hit));
    check({req, " redirect"}, 64'(pred_redirect), 64'(e_red));
    if (e_red) check({req, " target"}, pred_target, {a[63:16], e_tlo});
  endtask

  task automatic resolve(logic [63:0] a, logic tk, logic [15:0] tlo, logic ok);
    @(negedge clk);
    res_valid = 1'b1; res_key = a[15:0]; res_taken = tk;
    res_target_lo = tlo; res_correct = ok;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  localparam logic [63:0] A = 64'h0000_7777_0040_1230;
  localparam logic [63:0] B = 64'h0000_7777_0040_2468;

  task automatic t_reset();
    do_reset();
    check("R1 idle valid", 64'(pred_valid), 64'd0);
    lookup("R1 empty", A, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R2 valid drops", 64'(pred_valid), 64'd0);
  endtask

  task automatic t_score();
    do_reset();
    resolve(A, 1'b1, 16'hBEEF, 1'b0);
    lookup("R7 alloc cold", A, 1'b1, 1'b0, '0);
    resolve(A, 1'b1, 16'hBEEF, 1'b1);
    lookup("R4 score1", A, 1'b1, 1'b0, '0);
    resolve(A, 1'b1, 16'hBEEF, 1'b1);
    lookup("R4 R5 score2", A, 1'b1, 1'b1, 16'hBEEF);
    resolve(A, 1'b1, 16'hBEEF, 1'b1);
    resolve(A, 1'b1, 16'hBEEF, 1'b1);
    lookup("R6 sat top", A, 1'b1, 1'b1, 16'hBEEF);
    resolve(A, 1'b1, 16'hBEEF, 1'b0);
    lookup("R6 dec to 2", A, 1'b1, 1'b1, 16'hBEEF);
    resolve(A, 1'b1, 16'hBEEF, 1'b0);
    lookup("R6 dec to 1", A, 1'b1, 1'b0, '0);
    resolve(A, 1'b1, 16'hBEEF, 1'b0);
    resolve(A, 1'b1, 16'hBEEF, 1'b0);
    resolve(A, 1'b1, 16'hBEEF, 1'b1);
    resolve(A, 1'b1, 16'hBEEF, 1'b1);
    lookup("R6 floor", A, 1'b1, 1'b1, 16'hBEEF);
  endtask

  task automatic t_alias();
    lookup("R3 R5 alias", A ^ 64'h0000_0100_0000_0000, 1'b1, 1'b1, 16'hBEEF);
    lookup("R3 tag bit", A ^ 64'h8, 1'b0, 1'b0, '0);
    resolve(B, 1'b0, 16'h1111, 1'b1);
    lookup("R7 not taken", B, 1'b0, 1'b0, '0);
  endtask

  function automatic logic [63:0] ek(int k);
    return 64'h0000_ABCD_0000_0000 + 64'(k * 16 + 5);
  endfunction

  task automatic t_victim();
    do_reset();
    for (int k = 0; k < 8; k++) resolve(ek(k), 1'b1, 16'(k * 16'h111), 1'b0);
    for (int k = 0; k < 8; k++) lookup("R8 free first", ek(k), 1'b1, 1'b0, '0);
    for (int k = 0; k < 8; k++) if (k != 3 && k != 5) resolve(ek(k), 1'b1, '0, 1'b1);
    resolve(ek(20), 1'b1, 16'h2020, 1'b0);
    lookup("R8 min score out", ek(3), 1'b0, 1'b0, '0);
    lookup("R8 tie keep", ek(5), 1'b1, 1'b0, '0);
    lookup("R8 new in", ek(20), 1'b1, 1'b0, '0);
    resolve(ek(21), 1'b1, 16'h2121, 1'b0);
    lookup("R8 low index tie", ek(20), 1'b0, 1'b0, '0);
    lookup("R8 tie keep2", ek(5), 1'b1, 1'b0, '0);
    lookup("R8 new in2", ek(21), 1'b1, 1'b0, '0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    resolve(A, 1'b1, 16'h0A0A, 1'b0);
    resolve(A, 1'b1, 16'h0A0A, 1'b1);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = A;
    res_valid = 1'b1; res_key = A[15:0]; res_taken = 1'b1; res_correct = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0; res_valid = 1'b0;
    check("R9 old score", 64'(pred_redirect), 64'd0);
    lookup("R9 new score", A, 1'b1, 1'b1, 16'h0A0A);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = B;
    res_valid = 1'b1; res_key = B[15:0]; res_taken = 1'b1; res_correct = 1'b0;
    res_target_lo = 16'h0B0B;
    @(negedge clk);
    fetch_valid = 1'b0; res_valid = 1'b0;
    check("R9 old miss", 64'(pred_hit), 64'd0);
    lookup("R9 after alloc", B, 1'b1, 1'b0, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_score();
    t_alias();
    t_victim();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule